// File: doc/BRIEF.md
# DMA Paged Address Generator

This block forms the physical memory address for one DMA channel while a transfer runs, and it flags the last transfer. A page register supplies the top bits of the address. A 16-bit current-address counter supplies the low bits, and a 16-bit current-count counter tracks the transfers that remain. Each transfer strobe moves the address by one unit and lowers the count by one. When the count wraps from zero to all ones, terminal count pulses for that transfer.

Two packing modes exist. Byte mode places the counter directly under the page. Word mode shifts the counter up by one bit, forces address bit 0 to zero, and discards page bit 0. In both modes the counter wraps inside its window and never carries into the page. A programmed count of N-1 gives N transfers. With auto-reload set, terminal count copies the base address and base count back into the current counters. Without it, terminal count drops the channel's request enable.

Top module: `dma_page_addr_gen`

## Requirements
- R1: In byte mode (word_mode_i=0), phys_addr_o[23:16] equals the page register and phys_addr_o[15:0] equals the address counter.
- R2: In word mode (word_mode_i=1), phys_addr_o[0] is 0, phys_addr_o[16:1] equals the address counter, phys_addr_o[23:17] equals page bits 7:1, and page bit 0 has no effect on the output.
- R3: A transfer with addr_dec_i=0 adds one to the address counter, and the counter wraps from 0xFFFF to 0x0000. The page part of phys_addr_o stays unchanged.
- R4: A transfer with addr_dec_i=1 subtracts one from the address counter, and the counter wraps from 0x0000 to 0xFFFF without touching the page.
- R5: Each transfer lowers cur_cnt_o by one. A loaded count of N-1 yields exactly N transfers. tc_o is high only during the transfer that finds the count at 0x0000.
- R6: On terminal count with auto_init_i=0, the count becomes 0xFFFF, the address takes its normal step, and req_en_o clears. Otherwise req_en_o is set by req_en_set_i.
- R7: On terminal count with auto_init_i=1, the address and count counters reload from the values last loaded, and req_en_o is left unchanged.
- R8: A page load changes only the page field. The address counter and the count are not disturbed.
- R9: addr_ld_i and cnt_ld_i take priority over a transfer in the same cycle. A count load in that cycle suppresses terminal count.
- R10: After reset, the page, the address, the count and req_en_o are all zero, and tc_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_mode_i | input | 1 | 1: 16-bit word packing, 0: byte packing |
| auto_init_i | input | 1 | Reload from the base values on terminal count |
| addr_dec_i | input | 1 | Address counter counts down |
| page_ld_i | input | 1 | Load the page register |
| page_i | input | 8 | Page value |
| addr_ld_i | input | 1 | Load the base and current address |
| addr_i | input | 16 | Address value |
| cnt_ld_i | input | 1 | Load the base and current count |
| cnt_i | input | 16 | Count value (transfers minus one) |
| req_en_set_i | input | 1 | Set the request enable |
| xfer_i | input | 1 | One transfer happens this cycle |
| phys_addr_o | output | 24 | Physical address |
| cur_cnt_o | output | 16 | Current count |
| tc_o | output | 1 | Terminal count, high during the final transfer |
| req_en_o | output | 1 | Channel request enable |

## Verification
The bench goes after the window edges. An address at 0xFFFF is stepped up and an address at 0x0000 is stepped down. A design that carried into the page would jump to the next 64K or 128K window. Word mode runs with an odd page value, where a design that kept page bit 0 or failed to shift the counter would produce an odd address or one twice too low. A count of 2 is run to its end to catch an off-by-one that gives two or four transfers, or a terminal count flagged at 0x0001. Auto-reload, a page rewrite in the middle of a run, and loads that coincide with a transfer are also covered. These expose a design that keeps the wrapped value, that clobbers the low address when the page changes, or that lets the transfer win over the load.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned PHYS_W = CNT_W + PAGE_W;

  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;

  typedef enum logic {
    PACK_BYTE = 1'b0,
    PACK_WORD = 1'b1
  } pack_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int unsigned W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ld_i,
  input  logic [W-1:0]          val_i,
  input  logic                  step_i,
  input  logic                  reload_i,
  input  dma_pg_pkg::step_dir_e dir_i,
  output logic [W-1:0]          addr_o
);
  import dma_pg_pkg::*;

  logic [W-1:0] base_q, cur_q, stepped;

  // wraps inside the window; no carry leaves this counter
  always_comb begin
    if (dir_i == STEP_DOWN) stepped = cur_q - W'(1);
    else                    stepped = cur_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (ld_i) begin
      base_q <= val_i;
      cur_q  <= val_i;
    end else if (step_i) begin
      cur_q <= reload_i ? base_q : stepped;
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  input  logic         xfer_i,
  input  logic         auto_i,
  input  logic         en_set_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o,
  output logic         en_o
);
  logic [W-1:0] base_q, cur_q;
  logic         en_q, last;

  assign last = (cur_q == '0);
  // a count load in the same cycle pre-empts the terminal count
  assign tc_o = xfer_i & ~ld_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (ld_i) begin
      base_q <= val_i;
      cur_q  <= val_i;
    end else if (xfer_i) begin
      cur_q <= (tc_o && auto_i) ? base_q : cur_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                en_q <= 1'b0;
    else if (tc_o && !auto_i)   en_q <= 1'b0;
    else if (en_set_i)          en_q <= 1'b1;
  end

  assign cnt_o = cur_q;
  assign en_o  = en_q;
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8,
  localparam int unsigned OW = CW + PW
) (
  input  dma_pg_pkg::pack_e pack_i,
  input  logic [PW-1:0]     page_i,
  input  logic [CW-1:0]     ctr_i,
  output logic [OW-1:0]     phys_o
);
  import dma_pg_pkg::*;

  logic [OW-1:0] byte_map, word_map;

  assign byte_map = {page_i, ctr_i};
  // word packing: drop page bit 0, shift counter up one
  assign word_map = {page_i[PW-1:1], ctr_i, 1'b0};
  assign phys_o   = (pack_i == PACK_WORD) ? word_map : byte_map;
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int unsigned CNT_W  = dma_pg_pkg::CNT_W,
  parameter int unsigned PAGE_W = dma_pg_pkg::PAGE_W,
  localparam int unsigned PHYS_W = CNT_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              auto_init_i,
  input  logic              addr_dec_i,
  input  logic              page_ld_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              addr_ld_i,
  input  logic [CNT_W-1:0]  addr_i,
  input  logic              cnt_ld_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              req_en_set_i,
  input  logic              xfer_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic              tc_o,
  output logic              req_en_o
);
  import dma_pg_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  addr_cur;
  logic              tc;
  step_dir_e         dir;
  pack_e             pack;

  assign dir  = addr_dec_i  ? STEP_DOWN : STEP_UP;
  assign pack = word_mode_i ? PACK_WORD : PACK_BYTE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_q <= '0;
    else if (page_ld_i) page_q <= page_i;
  end

  dma_xfer_cnt #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_ld_i),
    .val_i    (cnt_i),
    .xfer_i   (xfer_i),
    .auto_i   (auto_init_i),
    .en_set_i (req_en_set_i),
    .cnt_o    (cur_cnt_o),
    .tc_o     (tc),
    .en_o     (req_en_o)
  );

  dma_addr_ctr #(.W(CNT_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (addr_ld_i),
    .val_i    (addr_i),
    .step_i   (xfer_i),
    .reload_i (tc & auto_init_i),
    .dir_i    (dir),
    .addr_o   (addr_cur)
  );

  dma_addr_map #(.CW(CNT_W), .PW(PAGE_W)) u_map (
    .pack_i (pack),
    .page_i (page_q),
    .ctr_i  (addr_cur),
    .phys_o (phys_addr_o)
  );

  assign tc_o = tc;
endmodule

// File: rtl/dma_page_addr_gen_chk.sv
module dma_page_addr_gen_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned PHYS_W = CNT_W + PAGE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_mode_i,
  input logic              auto_init_i,
  input logic              addr_dec_i,
  input logic              page_ld_i,
  input logic              addr_ld_i,
  input logic              cnt_ld_i,
  input logic              xfer_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [CNT_W-1:0]  cur_cnt_o,
  input logic              tc_o,
  input logic              req_en_o
);
  assert_page_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_ld_i |=> $stable(phys_addr_o[PHYS_W-1:CNT_W+1]));

  assert_cnt_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !cnt_ld_i && !tc_o) |=> cur_cnt_o == $past(cur_cnt_o) - CNT_W'(1));

  assert_cnt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !cnt_ld_i) |=> $stable(cur_cnt_o));

  assert_tc_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !auto_init_i) |=> (cur_cnt_o == '1) && !req_en_o);

  assert_addr_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !tc_o && !addr_ld_i && !addr_dec_i && !word_mode_i)
      |=> word_mode_i || (phys_addr_o[CNT_W-1:0] == $past(phys_addr_o[CNT_W-1:0]) + CNT_W'(1)));
endmodule

bind dma_page_addr_gen dma_page_addr_gen_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_mode_i (word_mode_i),
  .auto_init_i (auto_init_i),
  .addr_dec_i  (addr_dec_i),
  .page_ld_i   (page_ld_i),
  .addr_ld_i   (addr_ld_i),
  .cnt_ld_i    (cnt_ld_i),
  .xfer_i      (xfer_i),
  .phys_addr_o (phys_addr_o),
  .cur_cnt_o   (cur_cnt_o),
  .tc_o        (tc_o),
  .req_en_o    (req_en_o)
);

// File: tb/tb_dma_page_addr_gen.sv
module tb_dma_page_addr_gen;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        word_mode, auto_init, addr_dec, page_ld, addr_ld, cnt_ld, en_set, xfer;
  logic [7:0]  page_v;
  logic [15:0] addr_v, cnt_v;
  logic [23:0] phys;
  logic [15:0] cnt_o;
  logic        tc, req_en;

  dma_page_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode), .auto_init_i(auto_init),
    .addr_dec_i(addr_dec), .page_ld_i(page_ld), .page_i(page_v), .addr_ld_i(addr_ld),
    .addr_i(addr_v), .cnt_ld_i(cnt_ld), .cnt_i(cnt_v), .req_en_set_i(en_set),
    .xfer_i(xfer), .phys_addr_o(phys), .cur_cnt_o(cnt_o), .tc_o(tc), .req_en_o(req_en)
  );

  typedef struct {
    logic        tc;
    logic [23:0] addr;
    logic [15:0] cnt;
    logic        en;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;

  // reference state, kept from the requirements
  logic [7:0]  m_page;
  logic [15:0] m_addr, m_cnt, m_ba, m_bc;
  logic        m_en;

  // stimulus for the next step; strobes clear after each step
  logic        s_word = 0, s_auto = 0, s_dec = 0;
  logic        s_xfer = 0, s_pld = 0, s_ald = 0, s_cld = 0, s_en = 0;
  logic [7:0]  s_page = 0;
  logic [15:0] s_addr = 0, s_cnt = 0;

  function automatic logic [23:0] map(logic w, logic [7:0] p, logic [15:0] a);
    return w ? {p[7:1], a, 1'b0} : {p, a};
  endfunction

  task automatic step(string req);
    exp_t e;
    logic t;
    @(negedge clk);
    word_mode = s_word; auto_init = s_auto; addr_dec = s_dec;
    xfer = s_xfer; page_ld = s_pld; addr_ld = s_ald; cnt_ld = s_cld; en_set = s_en;
    page_v = s_page; addr_v = s_addr; cnt_v = s_cnt;
    t = s_xfer && !s_cld && (m_cnt == 16'h0000);
    if (s_pld) m_page = s_page;
    if (s_ald) begin m_ba = s_addr; m_addr = s_addr; end
    else if (s_xfer) m_addr = (t && s_auto) ? m_ba : (s_dec ? m_addr - 16'd1 : m_addr + 16'd1);
    if (s_cld) begin m_bc = s_cnt; m_cnt = s_cnt; end
    else if (s_xfer) m_cnt = (t && s_auto) ? m_bc : m_cnt - 16'd1;
    if (t && !s_auto) m_en = 1'b0;
    else if (s_en) m_en = 1'b1;
    e.tc = t; e.addr = map(s_word, m_page, m_addr); e.cnt = m_cnt; e.en = m_en; e.req = req;
    q.push_back(e);
    s_xfer = 0; s_pld = 0; s_ald = 0; s_cld = 0; s_en = 0;
  endtask

  // monitor: tc mid-cycle before the edge, state after the edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() != 0) begin
        e = q.pop_front();
        checks++;
        if (tc !== e.tc) begin
          fails++; $display("FAIL %s tc act=%0b exp=%0b", e.req, tc, e.tc);
        end
        @(posedge clk);
        #(CLK_P/4);
        checks++;
        if (phys !== e.addr || cnt_o !== e.cnt || req_en !== e.en) begin
          fails++;
          $display("FAIL %s act addr=%06h cnt=%04h en=%0b exp addr=%06h cnt=%04h en=%0b",
                   e.req, phys, cnt_o, req_en, e.addr, e.cnt, e.en);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    word_mode = 0; auto_init = 0; addr_dec = 0; page_ld = 0; addr_ld = 0;
    cnt_ld = 0; en_set = 0; xfer = 0; page_v = 0; addr_v = 0; cnt_v = 0;
    m_page = 0; m_addr = 0; m_cnt = 0; m_ba = 0; m_bc = 0; m_en = 0;
    #(CLK_P * 3);
    checks++;
    if (phys !== 24'h0 || cnt_o !== 16'h0 || tc !== 1'b0 || req_en !== 1'b0) begin
      fails++;
      $display("FAIL R10 act addr=%06h cnt=%04h tc=%0b en=%0b exp all zero", phys, cnt_o, tc, req_en);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 byte mapping, R3 increment
    s_pld = 1; s_page = 8'h12; s_ald = 1; s_addr = 16'h3456;
    s_cld = 1; s_cnt = 16'h0100; s_en = 1; step("R1");
    s_xfer = 1; step("R3");
    s_xfer = 1; step("R3");
    // R3 wrap inside the 64K window
    s_ald = 1; s_addr = 16'hFFFF; step("R3");
    s_xfer = 1; step("R3");
    // R4 decrement wrap
    s_dec = 1; s_xfer = 1; step("R4");
    s_xfer = 1; step("R4");
    s_dec = 0;
    // R2 word mode, odd page, window wrap at 128K
    s_word = 1; s_pld = 1; s_page = 8'h13; s_ald = 1; s_addr = 16'hFFFE; step("R2");
    s_xfer = 1; step("R2");
    s_xfer = 1; step("R2");
    s_pld = 1; s_page = 8'h12; step("R2");
    // R8 page rewrite keeps address and count
    s_word = 0; s_pld = 1; s_page = 8'hA5; step("R8");
    s_xfer = 1; step("R8");
    // R5/R6 count of 2 -> three transfers, then stop
    s_cld = 1; s_cnt = 16'h0002; s_en = 1; step("R5");
    s_xfer = 1; step("R5");
    s_xfer = 1; step("R5");
    s_xfer = 1; step("R6");
    s_en = 1; step("R6");
    s_xfer = 1; step("R6");
    // R7 auto reload
    s_auto = 1; s_ald = 1; s_addr = 16'h1000; s_cld = 1; s_cnt = 16'h0001; step("R7");
    s_xfer = 1; step("R7");
    s_xfer = 1; step("R7");
    s_xfer = 1; step("R7");
    s_auto = 0;
    // R9 loads win over a transfer in the same cycle
    s_cld = 1; s_cnt = 16'h0000; step("R9");
    s_xfer = 1; s_cld = 1; s_cnt = 16'h0005; s_ald = 1; s_addr = 16'h0042; step("R9");
    s_xfer = 1; step("R9");
    step("R9");
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule